// File: doc/BRIEF.md
# Processor Status Flag Register

An eight-bit status register for a small processor core. It stores the global interrupt enable, a single transfer bit used for moving one bit between general register values, and the arithmetic condition flags. The ALU updates the half-carry, overflow, negative, zero and carry flags through per-flag write enables, so an instruction that affects only some flags leaves the others alone. The sign flag has no storage of its own. It is formed at all times as negative XOR overflow.

Software reads and writes the whole byte through an I/O-mapped port at address 0x3F. The interrupt controller strobes interrupt acceptance, which clears the enable, and return-from-interrupt, which sets it. A bit-store strobe copies a selected bit of an operand into the transfer bit. The bit-load path returns the operand with the selected bit replaced by the transfer bit, and it is presented combinationally for the register file to write back.

Top module: `status_flag_reg`

## Requirements
- R1: After reset every stored bit is 0, so status_o reads 0x00 and interrupts are globally disabled.
- R2: Bit layout, MSB to LSB: 7 enable, 6 transfer, 5 half-carry, 4 sign, 3 overflow, 2 negative, 1 zero, 0 carry. A write with io_we_i high and io_addr_i equal to 0x3F loads bits 7,6,5,3,2,1,0 on the next edge. io_rdata_o shows the full byte when io_addr_i is 0x3F and 0x00 at any other address. A write to any other address changes nothing.
- R3: Bit 4 always equals bit 2 XOR bit 3. The value written to bit 4 is ignored.
- R4: alu_we_i and alu_flags_i use bit 4 for half-carry, 3 for overflow, 2 for negative, 1 for zero and 0 for carry. A flag loads its alu_flags_i bit only when its enable is set. Flags whose enable is clear keep their value.
- R5: An I/O write to the register wins over an ALU update of the same flag in the same cycle.
- R6: When bst_i is high, the transfer bit loads bit xfer_sel_i of xfer_op_i, unless an I/O write to the register occurs in the same cycle.
- R7: bld_data_o equals xfer_op_i with bit xfer_sel_i replaced by the current transfer bit.
- R8: irq_ack_i clears the enable bit and reti_i sets it. reti_i loses to an I/O write in the same cycle.
- R9: irq_ack_i clears the enable bit even when an I/O write or reti_i occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 6 | I/O address |
| io_we_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data (0 when not addressed) |
| alu_we_i | input | 5 | Per-flag ALU write enables {H,V,N,Z,C} |
| alu_flags_i | input | 5 | ALU flag values {H,V,N,Z,C} |
| bst_i | input | 1 | Bit-store strobe |
| xfer_op_i | input | 8 | Register operand for bit-store and bit-load |
| xfer_sel_i | input | 3 | Bit index for bit-store and bit-load |
| bld_data_o | output | 8 | Operand with selected bit replaced by the transfer bit |
| irq_ack_i | input | 1 | Interrupt accepted strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| status_o | output | 8 | Full status byte |
| irq_en_o | output | 1 | Global interrupt enable |

## Verification
The bench uses the default parameters: an eight-bit word, a six-bit I/O address and the register at 0x3F. With a six-bit address, half of the random accesses can land on 0x3F while the rest spread over the other 63 locations. This makes collisions between I/O writes, ALU masks, bit-store and the interrupt strobes frequent. Every transfer index from 0 to 7 is reachable, so both the bit-store selection and the bit-load insertion are exercised at each position.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned SEL_W  = $clog2(WORD_W);
  localparam int unsigned ALU_W  = 5;
  // bit positions in the status byte
  localparam int unsigned B_IE = 7;
  localparam int unsigned B_TB = 6;
  localparam int unsigned B_HC = 5;
  localparam int unsigned B_SG = 4;
  localparam int unsigned B_OV = 3;
  localparam int unsigned B_NG = 2;
  localparam int unsigned B_ZR = 1;
  localparam int unsigned B_CY = 0;
  // positions in the ALU update vector
  localparam int unsigned A_HC = 4;
  localparam int unsigned A_OV = 3;
  localparam int unsigned A_NG = 2;
  localparam int unsigned A_ZR = 1;
  localparam int unsigned A_CY = 0;
endpackage

// File: rtl/psr_bit_xfer.sv
module psr_bit_xfer
  import psr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              t_i,
  output logic              pick_o,
  output logic [WORD_W-1:0] ins_o
);
  assign pick_o = op_i[sel_i];

  always_comb begin
    ins_o = op_i;
    for (int i = 0; i < WORD_W; i++) begin
      if (sel_i == SEL_W'(i)) ins_o[i] = t_i;
    end
  end

  // R7: inserted bit is T, other bits pass through
  a_r7_bld_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_o[sel_i] == t_i) && ((ins_o ^ op_i) & ~(WORD_W'(1) << sel_i)) == '0);
endmodule

// File: rtl/psr_flag_core.sv
module psr_flag_core
  import psr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_hit_i,
  input  logic [WORD_W-1:0] io_wdata_i,
  input  logic [ALU_W-1:0]  alu_we_i,
  input  logic [ALU_W-1:0]  alu_flags_i,
  input  logic              bst_i,
  input  logic              bst_bit_i,
  input  logic              irq_ack_i,
  input  logic              reti_i,
  output logic [WORD_W-1:0] status_o
);
  logic ie_q, tb_q;
  logic [ALU_W-1:0] fl_q;

  // stored flag order inside fl_q matches the ALU vector
  localparam int unsigned MAP [ALU_W] = '{B_CY, B_ZR, B_NG, B_OV, B_HC};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0;
      tb_q <= 1'b0;
    end else begin
      if (irq_ack_i)     ie_q <= 1'b0;
      else if (io_hit_i) ie_q <= io_wdata_i[B_IE];
      else if (reti_i)   ie_q <= 1'b1;
      if (io_hit_i)      tb_q <= io_wdata_i[B_TB];
      else if (bst_i)    tb_q <= bst_bit_i;
    end
  end

  for (genvar g = 0; g < ALU_W; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           fl_q[g] <= 1'b0;
      else if (io_hit_i)     fl_q[g] <= io_wdata_i[MAP[g]];
      else if (alu_we_i[g])  fl_q[g] <= alu_flags_i[g];
    end
  end

  always_comb begin
    status_o       = '0;
    status_o[B_IE] = ie_q;
    status_o[B_TB] = tb_q;
    status_o[B_HC] = fl_q[A_HC];
    status_o[B_OV] = fl_q[A_OV];
    status_o[B_NG] = fl_q[A_NG];
    status_o[B_ZR] = fl_q[A_ZR];
    status_o[B_CY] = fl_q[A_CY];
    status_o[B_SG] = fl_q[A_NG] ^ fl_q[A_OV];
  end

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> !status_o[B_IE]);
  a_r8_reti_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !irq_ack_i && !io_hit_i) |=> status_o[B_IE]);
  a_r4_carry_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_hit_i && !alu_we_i[A_CY]) |=> $stable(status_o[B_CY]));
  a_r5_io_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hit_i |=> status_o[B_ZR] == $past(io_wdata_i[B_ZR]));
  a_r6_bst_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_i && !io_hit_i) |=> status_o[B_TB] == $past(bst_bit_i));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import psr_pkg::*;
#(
  parameter int unsigned IO_ADDR_W = 6,
  parameter logic [IO_ADDR_W-1:0] REG_ADDR = 6'h3F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IO_ADDR_W-1:0] io_addr_i,
  input  logic                 io_we_i,
  input  logic [WORD_W-1:0]    io_wdata_i,
  output logic [WORD_W-1:0]    io_rdata_o,
  input  logic [ALU_W-1:0]     alu_we_i,
  input  logic [ALU_W-1:0]     alu_flags_i,
  input  logic                 bst_i,
  input  logic [WORD_W-1:0]    xfer_op_i,
  input  logic [SEL_W-1:0]     xfer_sel_i,
  output logic [WORD_W-1:0]    bld_data_o,
  input  logic                 irq_ack_i,
  input  logic                 reti_i,
  output logic [WORD_W-1:0]    status_o,
  output logic                 irq_en_o
);
  logic addr_hit, io_hit, pick;

  assign addr_hit = (io_addr_i == REG_ADDR);
  assign io_hit   = io_we_i && addr_hit;

  psr_bit_xfer u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (xfer_op_i),
    .sel_i  (xfer_sel_i),
    .t_i    (status_o[B_TB]),
    .pick_o (pick),
    .ins_o  (bld_data_o)
  );

  psr_flag_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_hit_i    (io_hit),
    .io_wdata_i  (io_wdata_i),
    .alu_we_i    (alu_we_i),
    .alu_flags_i (alu_flags_i),
    .bst_i       (bst_i),
    .bst_bit_i   (pick),
    .irq_ack_i   (irq_ack_i),
    .reti_i      (reti_i),
    .status_o    (status_o)
  );

  assign io_rdata_o = addr_hit ? status_o : '0;
  assign irq_en_o   = status_o[B_IE];

  a_r3_sign_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hit |-> io_rdata_o[B_SG] == (io_rdata_o[B_NG] ^ io_rdata_o[B_OV]));
  a_r2_miss_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hit |-> io_rdata_o == '0);
endmodule

// File: tb/status_flag_reg_tb_top.sv
module status_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] io_addr = '0;
  logic       io_we = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [4:0] alu_we = '0, alu_flags = '0;
  logic       bst = 1'b0;
  logic [7:0] xop = '0;
  logic [2:0] xsel = '0;
  logic [7:0] bld;
  logic       ack = 1'b0, reti = 1'b0;
  logic [7:0] status;
  logic       irq_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // model state
  bit m_i, m_t, m_h, m_v, m_n, m_z, m_c;

  always #10 clk = ~clk;

  status_flag_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_we_i(io_we),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .alu_we_i(alu_we),
    .alu_flags_i(alu_flags), .bst_i(bst), .xfer_op_i(xop), .xfer_sel_i(xsel),
    .bld_data_o(bld), .irq_ack_i(ack), .reti_i(reti), .status_o(status),
    .irq_en_o(irq_en)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_byte();
    return {m_i, m_t, m_h, m_n ^ m_v, m_v, m_n, m_z, m_c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_i, m_t, m_h, m_v, m_n, m_z, m_c} = '0;
    end else begin
      automatic bit hit = io_we && (io_addr == 6'd63);
      if (ack) m_i = 0; else if (hit) m_i = io_wdata[7]; else if (reti) m_i = 1;
      if (hit) m_t = io_wdata[6]; else if (bst) m_t = xop[xsel];
      if (hit) begin
        m_h = io_wdata[5]; m_v = io_wdata[3]; m_n = io_wdata[2];
        m_z = io_wdata[1]; m_c = io_wdata[0];
      end else begin
        if (alu_we[4]) m_h = alu_flags[4];
        if (alu_we[3]) m_v = alu_flags[3];
        if (alu_we[2]) m_n = alu_flags[2];
        if (alu_we[1]) m_z = alu_flags[1];
        if (alu_we[0]) m_c = alu_flags[0];
      end
    end
  end

  task automatic compare_all();
    logic [7:0] e = m_byte();
    logic [7:0] eb = xop;
    eb[xsel] = m_t;
    chk("R8/R9 enable", {7'd0, status[7]}, {7'd0, e[7]});
    chk("R6 transfer", {7'd0, status[6]}, {7'd0, e[6]});
    chk("R3 sign", {7'd0, status[4]}, {7'd0, e[4]});
    chk("R4/R5 flags", status & 8'h2F, e & 8'h2F);
    chk("R8 irq_en_o", {7'd0, irq_en}, {7'd0, e[7]});
    chk("R2 readback", io_rdata, (io_addr == 6'd63) ? e : 8'h00);
    chk("R7 bit-load", bld, eb);
  endtask

  task automatic drive(bit w, logic [5:0] a, logic [7:0] d, logic [4:0] we,
                       logic [4:0] f, bit b, logic [7:0] o, logic [2:0] s,
                       bit k, bit r);
    io_we = w; io_addr = a; io_wdata = d; alu_we = we; alu_flags = f;
    bst = b; xop = o; xsel = s; ack = k; reti = r;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset", status, 8'h00);
    rst_n = 1'b1;
    step();
    // R2/R3: write all ones, sign ignored -> N^V = 0
    drive(1, 6'h3F, 8'hFF, 0, 0, 0, 0, 0, 0, 0); step();
    chk("R3 sign ignores write", status, 8'hEF);
    // R2: miss address write ignored
    drive(1, 6'h12, 8'h00, 0, 0, 0, 0, 0, 0, 0); step();
    chk("R2 miss write", status, 8'hEF);
    // R9: ack beats io write and reti
    drive(1, 6'h3F, 8'h80, 0, 0, 0, 0, 0, 1, 1); step();
    chk("R9 ack wins", {7'd0, status[7]}, 8'h00);
    // R8: reti sets enable
    drive(0, 6'h00, 0, 0, 0, 0, 0, 0, 0, 1); step();
    chk("R8 reti", {7'd0, status[7]}, 8'h01);
    // R5: io write beats ALU
    drive(1, 6'h3F, 8'h04, 5'h1F, 5'h1B, 0, 0, 0, 0, 0); step();
    chk("R5 io over alu", status & 8'h3F, 8'h14);
    // R4: mask only carry
    drive(0, 6'h00, 0, 5'h01, 5'h1F, 0, 0, 0, 0, 0); step();
    chk("R4 masked", status & 8'h3F, 8'h15);
    // R6/R7: bst bit 5 of 0x20 then bld at bit 0
    drive(0, 6'h00, 0, 0, 0, 1, 8'h20, 3'd5, 0, 0); step();
    chk("R6 bst", {7'd0, status[6]}, 8'h01);
    drive(0, 6'h3F, 0, 0, 0, 0, 8'h00, 3'd0, 0, 0); #1;
    chk("R7 bld", bld, 8'h01);
    step();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3) == 0, ($urandom_range(0, 1) ? 6'h3F : 6'($urandom)),
            8'($urandom), 5'($urandom), 5'($urandom), $urandom_range(0, 3) == 0,
            8'($urandom), 3'($urandom), $urandom_range(0, 5) == 0,
            $urandom_range(0, 5) == 0);
      step();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule